// File: doc/BRIEF.md
# Load-Use Stall Unit

This unit sits beside the decode stage of a five-stage in-order pipeline and decides when the instruction in decode has to wait for a load. A value being loaded from memory only exists at the end of the memory stage. Forwarding therefore cannot deliver it to the instruction directly behind the load. When the instruction in the execute-bound latch (ID/EX) is a load, and its destination register is a source of the instruction in the decode latch (IF/ID), the unit holds the program counter and IF/ID for one cycle. In that same cycle it tells the pipeline to clear ID/EX, so that a no-op moves into execute.

Which sources count depends on the consumer's format. A register-register consumer has both of its source fields compared. A store is given as this kind, because it reads both fields. An immediate consumer has only its first source field compared. A load targeting register 0 never stalls, because that register is constant.

A two-state machine makes sure each detection produces exactly one bubble. In state FLOW the unit raises a stall whenever a hazard is seen, and it takes transition FLOW->BUBBLE on that cycle. In state BUBBLE no stall is raised, and it always takes transition BUBBLE->FLOW. If there is no hazard, FLOW stays in FLOW (transition FLOW->FLOW). Reset puts the machine in FLOW. In a correctly wired pipeline the cleared latch no longer holds the load after the bubble, so the hold releases without any counter.

Top module: `lduse_interlock`

## Requirements
- R1: When `idex_is_load` is 0, the unit never stalls: `pc_we`=1, `ifid_we`=1, `idex_flush`=0.
- R2: For a register-register or store consumer (`ifid_imm`=0), a load whose `idex_rt` equals `ifid_rs` (non-zero) causes a stall in that same cycle.
- R3: For `ifid_imm`=0, a load whose `idex_rt` equals `ifid_rt` (non-zero) causes a stall. If the load matches neither source field, there is no stall.
- R4: For an immediate consumer (`ifid_imm`=1), only `ifid_rs` is compared. A match on `ifid_rt` alone causes no stall.
- R5: A load with `idex_rt` equal to 0 (register 0) never causes a stall, whatever the source fields hold.
- R6: The three outputs always agree. During a stall the unit drives `pc_we`=0, `ifid_we`=0 and `idex_flush`=1. At all other times it drives `pc_we`=1, `ifid_we`=1 and `idex_flush`=0.
- R7: A stall lasts exactly one cycle. The cycle after a stall never stalls, even if the inputs are unchanged. In the cycle after that, the unit can stall again.
- R8: Reset (`rst_n`=0, asynchronous) returns the machine to FLOW, including when it is in BUBBLE. A hazard in the first cycle after reset stalls at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| idex_is_load | input | 1 | ID/EX holds a load |
| idex_rt | input | ADDR_W | Destination register of the instruction in ID/EX |
| ifid_rs | input | ADDR_W | First source register of the instruction in IF/ID |
| ifid_rt | input | ADDR_W | Second source register of the instruction in IF/ID |
| ifid_imm | input | 1 | 1 = immediate consumer, 0 = register-register or store |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | IF/ID latch write enable |
| idex_flush | output | 1 | Clear ID/EX to a no-op |

## Verification
The assertions check on every cycle that the three outputs agree with each other. They also check that no stall happens without a load or with a register-0 destination, that an immediate consumer never stalls on its second field alone, that a stall is never followed by another stall, and that a register-register match seen in FLOW does stall. Only the bench's scenarios can show the full detection table over chosen field patterns. They also show the machine coming back out of reset mid-bubble, and a modelled pipeline where clearing ID/EX removes the load and lets the consumer move on.

// File: rtl/lduse_pkg.sv
package lduse_pkg;

    typedef enum logic {
        ST_FLOW   = 1'b0,
        ST_BUBBLE = 1'b1
    } lu_state_e;

    typedef enum logic {
        CONS_REGREG = 1'b0,
        CONS_IMM    = 1'b1
    } cons_kind_e;

endpackage

// File: rtl/lduse_cmp.sv
module lduse_cmp #(
    parameter int unsigned ADDR_W         = 5,
    parameter bit          ZERO_HARDWIRED = 1'b1
) (
    input  logic [ADDR_W-1:0] dest,
    input  logic [ADDR_W-1:0] src,
    input  logic              src_used,
    output logic              hit
);

    generate
        if (ZERO_HARDWIRED) begin : g_zero
            // register 0 is constant, so writing it creates no dependence
            assign hit = src_used && (dest == src) && (dest != '0);
        end else begin : g_plain
            assign hit = src_used && (dest == src);
        end
    endgenerate

endmodule

// File: rtl/lduse_detect.sv
module lduse_detect
    import lduse_pkg::*;
#(
    parameter int unsigned ADDR_W         = 5,
    parameter bit          ZERO_HARDWIRED = 1'b1
) (
    input  logic              is_load,
    input  logic [ADDR_W-1:0] dest,
    input  logic [ADDR_W-1:0] src_a,
    input  logic [ADDR_W-1:0] src_b,
    input  cons_kind_e        kind,
    output logic              hazard
);

    localparam int unsigned NUM_SRC = 2;

    logic [NUM_SRC-1:0][ADDR_W-1:0] srcs;
    logic [NUM_SRC-1:0]             used;
    logic [NUM_SRC-1:0]             hits;

    assign srcs = {src_b, src_a};
    // first field is always read; second only by register-register / store
    assign used = {(kind == CONS_REGREG), 1'b1};

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            lduse_cmp #(
                .ADDR_W        (ADDR_W),
                .ZERO_HARDWIRED(ZERO_HARDWIRED)
            ) u_cmp (
                .dest    (dest),
                .src     (srcs[i]),
                .src_used(used[i]),
                .hit     (hits[i])
            );
        end
    endgenerate

    assign hazard = is_load && (|hits);

endmodule

// File: rtl/lduse_fsm.sv
module lduse_fsm
    import lduse_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hazard,
    output logic stall
);

    lu_state_e state_q;
    lu_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FLOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = ST_FLOW;
        unique case (state_q)
            ST_FLOW:   state_d = hazard ? ST_BUBBLE : ST_FLOW;
            ST_BUBBLE: state_d = ST_FLOW;
            default:   state_d = ST_FLOW;
        endcase
    end

    always_comb begin
        stall = 1'b0;
        unique case (state_q)
            ST_FLOW:   stall = hazard;
            ST_BUBBLE: stall = 1'b0;
            default:   stall = 1'b0;
        endcase
    end

endmodule

// File: rtl/lduse_interlock.sv
module lduse_interlock
    import lduse_pkg::*;
#(
    parameter int unsigned ADDR_W         = 5,
    parameter bit          ZERO_HARDWIRED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idex_is_load,
    input  logic [ADDR_W-1:0] idex_rt,
    input  logic [ADDR_W-1:0] ifid_rs,
    input  logic [ADDR_W-1:0] ifid_rt,
    input  logic              ifid_imm,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              idex_flush
);

    cons_kind_e kind;
    logic       hazard;
    logic       stall;

    assign kind = cons_kind_e'(ifid_imm);

    lduse_detect #(
        .ADDR_W        (ADDR_W),
        .ZERO_HARDWIRED(ZERO_HARDWIRED)
    ) u_detect (
        .is_load(idex_is_load),
        .dest   (idex_rt),
        .src_a  (ifid_rs),
        .src_b  (ifid_rt),
        .kind   (kind),
        .hazard (hazard)
    );

    lduse_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .hazard(hazard),
        .stall (stall)
    );

    assign pc_we      = !stall;
    assign ifid_we    = !stall;
    assign idex_flush = stall;

endmodule

// File: rtl/lduse_interlock_chk.sv
module lduse_interlock_chk #(
    parameter int unsigned ADDR_W         = 5,
    parameter bit          ZERO_HARDWIRED = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              idex_is_load,
    input logic [ADDR_W-1:0] idex_rt,
    input logic [ADDR_W-1:0] ifid_rs,
    input logic [ADDR_W-1:0] ifid_rt,
    input logic              ifid_imm,
    input logic              pc_we,
    input logic              ifid_we,
    input logic              idex_flush
);

    p_no_load_no_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !idex_is_load |-> !idex_flush);

    p_rr_match_stalls_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(idex_flush) && idex_is_load && !ifid_imm && (idex_rt != '0)
         && ((idex_rt == ifid_rs) || (idex_rt == ifid_rt))) |-> idex_flush);

    p_imm_rs_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ifid_imm && (idex_rt != ifid_rs)) |-> !idex_flush);

    p_reg0_never_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ZERO_HARDWIRED && (idex_rt == '0)) |-> !idex_flush);

    p_outputs_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we == ifid_we) && (idex_flush == !pc_we));

    p_single_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
        idex_flush |=> !idex_flush);

endmodule

bind lduse_interlock lduse_interlock_chk #(
    .ADDR_W        (ADDR_W),
    .ZERO_HARDWIRED(ZERO_HARDWIRED)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .idex_is_load(idex_is_load),
    .idex_rt     (idex_rt),
    .ifid_rs     (ifid_rs),
    .ifid_rt     (ifid_rt),
    .ifid_imm    (ifid_imm),
    .pc_we       (pc_we),
    .ifid_we     (ifid_we),
    .idex_flush  (idex_flush)
);

// File: tb/sim_lduse_interlock.sv
`timescale 1ns/1ps
module sim_lduse_interlock;

    localparam int W = 5;
    localparam int NV = 11;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         idex_is_load = 1'b0;
    logic [W-1:0] idex_rt = '0;
    logic [W-1:0] ifid_rs = '0;
    logic [W-1:0] ifid_rt = '0;
    logic         ifid_imm = 1'b0;
    logic         pc_we, ifid_we, idex_flush;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lduse_interlock #(.ADDR_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .idex_is_load(idex_is_load), .idex_rt(idex_rt),
        .ifid_rs(ifid_rs), .ifid_rt(ifid_rt), .ifid_imm(ifid_imm),
        .pc_we(pc_we), .ifid_we(ifid_we), .idex_flush(idex_flush)
    );

    // {req[3:0], load, dest[4:0], rs[4:0], rt[4:0], imm, expect_stall}
    localparam logic [21:0] VEC [NV] = '{
        {4'd1, 1'b0, 5'd3,  5'd3,  5'd3,  1'b0, 1'b0},
        {4'd1, 1'b0, 5'd7,  5'd7,  5'd1,  1'b1, 1'b0},
        {4'd2, 1'b1, 5'd4,  5'd4,  5'd9,  1'b0, 1'b1},
        {4'd2, 1'b1, 5'd31, 5'd31, 5'd0,  1'b0, 1'b1},
        {4'd3, 1'b1, 5'd6,  5'd2,  5'd6,  1'b0, 1'b1},
        {4'd3, 1'b1, 5'd12, 5'd1,  5'd2,  1'b0, 1'b0},
        {4'd4, 1'b1, 5'd8,  5'd8,  5'd3,  1'b1, 1'b1},
        {4'd4, 1'b1, 5'd9,  5'd2,  5'd9,  1'b1, 1'b0},
        {4'd5, 1'b1, 5'd0,  5'd0,  5'd0,  1'b0, 1'b0},
        {4'd5, 1'b1, 5'd0,  5'd0,  5'd5,  1'b1, 1'b0},
        {4'd3, 1'b1, 5'd10, 5'd3,  5'd10, 1'b0, 1'b1}
    };

    function automatic string req_name(input int r);
        case (r)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            default: return "R?";
        endcase
    endfunction

    task automatic check_out(input string req, input bit exp_stall);
        logic [2:0] act, exp;
        act = {pc_we, ifid_we, idex_flush};
        exp = {~exp_stall, ~exp_stall, exp_stall};
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {pc_we,ifid_we,idex_flush} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input bit ld, input logic [W-1:0] d, input logic [W-1:0] s,
                         input logic [W-1:0] t, input bit imm);
        idex_is_load = ld; idex_rt = d; ifid_rs = s; ifid_rt = t; ifid_imm = imm;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // R8: reset state, idle inputs give no stall
        drive(0, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        #2 check_out("R8 reset", 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: hazard in first cycle after reset stalls at once
        drive(1, 5'd4, 5'd4, 5'd1, 0);
        #2 check_out("R8 first hazard", 1'b1);
        @(negedge clk);
        drive(0, 0, 0, 0, 0);
        @(negedge clk);

        // table walk (R6 covered by every comparison of all three outputs)
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][17], VEC[i][16:12], VEC[i][11:7], VEC[i][6:2], VEC[i][1]);
            #2 check_out({req_name(int'(VEC[i][21:18])), "/R6 vector"}, VEC[i][0]);
            @(negedge clk);
            drive(0, 0, 0, 0, 0);
            @(negedge clk);
        end

        // R7: held hazard -> stall, no stall, stall again
        drive(1, 5'd7, 5'd7, 5'd2, 0);
        #2 check_out("R7 first cycle", 1'b1);
        @(negedge clk);
        #2 check_out("R7 second cycle", 1'b0);
        @(negedge clk);
        #2 check_out("R7 third cycle", 1'b1);
        @(negedge clk);
        drive(0, 0, 0, 0, 0);
        @(negedge clk);

        // R7: modelled pipeline; the flush removes the load from ID/EX
        drive(1, 5'd9, 5'd1, 5'd9, 0);
        #2 check_out("R7 pipe stall", 1'b1);
        @(negedge clk);
        drive(0, 5'd0, 5'd1, 5'd9, 0);   // bubble in ID/EX, consumer held
        #2 check_out("R7 pipe release", 1'b0);
        @(negedge clk);
        drive(0, 5'd9, 5'd3, 5'd4, 1);   // consumer advanced into ID/EX
        #2 check_out("R7 pipe advance", 1'b0);
        @(negedge clk);

        // R8: reset while in BUBBLE, then hazard stalls immediately
        drive(1, 5'd5, 5'd5, 5'd5, 1);
        #2 check_out("R8 pre-reset stall", 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        @(negedge clk);
        rst_n = 1'b1;
        #2 check_out("R8 stall after mid-bubble reset", 1'b1);
        @(negedge clk);
        drive(0, 0, 0, 0, 0);
        @(negedge clk);

        summary();
    end

endmodule